// File: doc/BRIEF.md
# Attack Event Monitor

The monitor sits between a set of bus firewalls and the security controller. Every firewall owns a dedicated attack-flag wire into the monitor. A raised flag is captured in that firewall's own event register, together with the current value of a free-running timestamp counter. The flag also sets a sticky bit in a summary register that has one bit per firewall. While any summary bit is set, the monitor holds an interrupt to the controller. The controller reads the registers and clears summary bits through a small register port, using write-one-to-clear.

The monitor also stalls flagged firewalls so that their security rules can be rewritten. It raises a block line to each flagged firewall in the cycle after the flag. The blocked firewalls are then handed to the controller one at a time, lowest bit position first. A release state machine has two states:
- `ST_IDLE`: nothing is being served. The transition *pick* moves to `ST_SERVE` when any block line is high and latches the lowest blocked index.
- `ST_SERVE`: the chosen index is presented to the controller. The transition *finish* returns to `ST_IDLE` when the controller signals that the update is complete. That firewall's block line drops on the same edge, and the other firewalls stay blocked until their own turn.

Top module: `aem_monitor`

## Requirements
- R1: After reset, the summary register reads 0, `irq` is 0, every `fw_block` line is 0 and `serve_valid` is 0.
- R2: A high `attack_flag[i]` sampled on a clock edge sets bit i of the summary register (address 0, bit i = firewall i) on that edge. The bit then stays set after the flag drops.
- R3: The event register of firewall i (address 1+i, bits TS_W-1:0) holds the timestamp counter value from the edge where the flag was sampled. A later flag from the same firewall overwrites it with the newer value.
- R4: `irq` is high exactly while at least one summary bit is set. It is therefore high in the cycle after any flag, and it stays high until every bit has been cleared.
- R5: A write to address 0 clears each summary bit whose write-data bit is 1 and leaves the other bits alone. A flag sampled on the same edge keeps its bit set. Writes to any other address have no effect.
- R6: `fw_block[i]` rises on the edge that samples `attack_flag[i]` and stays high until firewall i is released.
- R7: From `ST_IDLE` with any block line high, the next edge enters `ST_SERVE`, with `serve_valid`=1 and `serve_id` set to the lowest blocked index. `serve_id` holds steady until `upd_done` arrives.
- R8: `upd_done` sampled in `ST_SERVE` drops the block line of the served firewall only, unless that firewall flags again on the same edge. The machine returns to `ST_IDLE` and picks the next blocked firewall on the following edge.
- R9: `upd_done` sampled while `serve_valid` is 0 changes neither `fw_block` nor `serve_valid`.
- R10: A flag from a firewall that is already blocked does not queue it a second time. One release clears its block line, and it is not served again.
- R11: The timestamp counter (address N_FW+1) starts at 0 after reset, adds one on every clock edge and wraps modulo 2^TS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| attack_flag | input | N_FW | One attack flag per firewall |
| upd_done | input | 1 | Controller finished updating the served firewall |
| reg_addr | input | AW | Register address: 0 summary, 1..N_FW event registers, N_FW+1 timestamp |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | N_FW | Write-one-to-clear mask for the summary register |
| reg_rdata | output | RD_W | Read data of the addressed register, combinational |
| irq | output | 1 | Interrupt to the security controller |
| fw_block | output | N_FW | Per-firewall stall lines |
| serve_valid | output | 1 | A firewall is being served for update |
| serve_id | output | IW | Index of the served firewall |

## Verification
The checker watches, on every cycle, the rules that link the ports over time:
- a flag is followed by `irq` and by its block line;
- the served index is always blocked and stays steady until `upd_done`;
- a block line only falls singly, and only after `upd_done` during service;
- `upd_done` while idle changes nothing.

Other behaviours need whole scenarios, and the bench covers them. For every non-empty flag pattern, it checks the exact ascending service order and the contents of the timestamped event registers. It also checks partial write-one-to-clear, a flag winning over a clear on the same edge, re-flagging of a blocked firewall, and wrap of the timestamp.

// File: rtl/aem_pkg.sv
package aem_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } rel_state_e;
endpackage

// File: rtl/aem_ts_counter.sv
module aem_ts_counter #(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    logic [TS_W-1:0] ts_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ts_q <= '0;
        else        ts_q <= ts_q + 1'b1;
    end

    assign ts = ts_q;
endmodule

// File: rtl/aem_event_bank.sv
module aem_event_bank #(
    parameter int N_FW = 4,
    parameter int TS_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_FW-1:0]      flag,
    input  logic                 clr_en,
    input  logic [N_FW-1:0]      clr_mask,
    input  logic [TS_W-1:0]      ts,
    output logic [N_FW-1:0]      main_q,
    output logic [N_FW*TS_W-1:0] stamps
);
    for (genvar g = 0; g < N_FW; g++) begin : g_fw
        logic            hit_q;
        logic [TS_W-1:0] stamp_q;

        // a flag on the same edge wins over a clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q   <= 1'b0;
                stamp_q <= '0;
            end else if (flag[g]) begin
                hit_q   <= 1'b1;
                stamp_q <= ts;
            end else if (clr_en && clr_mask[g]) begin
                hit_q   <= 1'b0;
            end
        end

        assign main_q[g]                 = hit_q;
        assign stamps[g*TS_W +: TS_W]    = stamp_q;
    end
endmodule

// File: rtl/aem_release_fsm.sv
module aem_release_fsm
    import aem_pkg::*;
#(
    parameter int N_FW = 4,
    localparam int IW  = (N_FW > 1) ? $clog2(N_FW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_FW-1:0] flag,
    input  logic            upd_done,
    output logic [N_FW-1:0] block,
    output logic            serve_valid,
    output logic [IW-1:0]   serve_id
);
    rel_state_e      state_q, state_d;
    logic [IW-1:0]   head_q, head_d, pick;
    logic [N_FW-1:0] blocked_q, clr;

    // lowest set bit has priority
    always_comb begin
        pick = '0;
        for (int i = N_FW - 1; i >= 0; i--) begin
            if (blocked_q[i]) pick = IW'(i);
        end
    end

    always_comb begin
        state_d = state_q;
        head_d  = head_q;
        clr     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (|blocked_q) begin
                    state_d = ST_SERVE;
                    head_d  = pick;
                end
            end
            ST_SERVE: begin
                if (upd_done) begin
                    state_d     = ST_IDLE;
                    clr[head_q] = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            head_q    <= '0;
            blocked_q <= '0;
        end else begin
            state_q   <= state_d;
            head_q    <= head_d;
            blocked_q <= (blocked_q & ~clr) | flag;
        end
    end

    // outputs
    always_comb begin
        block       = blocked_q;
        serve_valid = (state_q == ST_SERVE);
        serve_id    = head_q;
    end
endmodule

// File: rtl/aem_monitor.sv
module aem_monitor #(
    parameter int N_FW  = 4,
    parameter int TS_W  = 16,
    parameter int RD_W  = 32,
    localparam int AW   = $clog2(N_FW + 2),
    localparam int IW   = (N_FW > 1) ? $clog2(N_FW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_FW-1:0] attack_flag,
    input  logic            upd_done,
    input  logic [AW-1:0]   reg_addr,
    input  logic            reg_wr,
    input  logic [N_FW-1:0] reg_wdata,
    output logic [RD_W-1:0] reg_rdata,
    output logic            irq,
    output logic [N_FW-1:0] fw_block,
    output logic            serve_valid,
    output logic [IW-1:0]   serve_id
);
    localparam logic [AW-1:0] TS_ADDR = AW'(N_FW + 1);

    logic [TS_W-1:0]      ts;
    logic [N_FW-1:0]      main_q;
    logic [N_FW*TS_W-1:0] stamps;
    logic                 clr_en;

    assign clr_en = reg_wr && (reg_addr == '0);

    aem_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk  (clk),
        .rst_n(rst_n),
        .ts   (ts)
    );

    aem_event_bank #(.N_FW(N_FW), .TS_W(TS_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag    (attack_flag),
        .clr_en  (clr_en),
        .clr_mask(reg_wdata),
        .ts      (ts),
        .main_q  (main_q),
        .stamps  (stamps)
    );

    aem_release_fsm #(.N_FW(N_FW)) u_rel (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag       (attack_flag),
        .upd_done   (upd_done),
        .block      (fw_block),
        .serve_valid(serve_valid),
        .serve_id   (serve_id)
    );

    assign irq = |main_q;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == '0) begin
            reg_rdata[N_FW-1:0] = main_q;
        end else if (reg_addr == TS_ADDR) begin
            reg_rdata[TS_W-1:0] = ts;
        end else begin
            for (int i = 0; i < N_FW; i++) begin
                if (reg_addr == AW'(i + 1)) reg_rdata[TS_W-1:0] = stamps[i*TS_W +: TS_W];
            end
        end
    end
endmodule

// File: rtl/aem_chk.sv
module aem_chk #(
    parameter int N_FW = 4,
    localparam int IW  = (N_FW > 1) ? $clog2(N_FW) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_FW-1:0] attack_flag,
    input logic            upd_done,
    input logic            irq,
    input logic [N_FW-1:0] fw_block,
    input logic            serve_valid,
    input logic [IW-1:0]   serve_id
);
    // R4
    flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|attack_flag) |=> irq);

    // R6
    flag_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|attack_flag) |=> ((fw_block & $past(attack_flag)) == $past(attack_flag)));

    // R7
    serve_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serve_valid |-> fw_block[serve_id]);

    // R7
    serve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_valid && !upd_done) |=> (serve_valid && $stable(serve_id)));

    // R8
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(fw_block) & ~fw_block) != '0) |->
            ($past(serve_valid && upd_done) && ($countones($past(fw_block) & ~fw_block) == 1)));

    // R9
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!serve_valid && upd_done && !(|attack_flag)) |=> (fw_block == $past(fw_block)));
endmodule

bind aem_monitor aem_chk #(.N_FW(N_FW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .attack_flag(attack_flag),
    .upd_done   (upd_done),
    .irq        (irq),
    .fw_block   (fw_block),
    .serve_valid(serve_valid),
    .serve_id   (serve_id)
);

// File: tb/aem_monitor_tb.sv
module aem_monitor_tb;
    localparam int N_FW = 4;
    localparam int TS_W = 6;
    localparam int RD_W = 32;
    localparam int AW   = $clog2(N_FW + 2);
    localparam int IW   = $clog2(N_FW);
    localparam int TSM  = (1 << TS_W) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N_FW-1:0] attack_flag = '0;
    logic            upd_done = 1'b0;
    logic [AW-1:0]   reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [N_FW-1:0] reg_wdata = '0;
    logic [RD_W-1:0] reg_rdata;
    logic            irq;
    logic [N_FW-1:0] fw_block;
    logic            serve_valid;
    logic [IW-1:0]   serve_id;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    aem_monitor #(.N_FW(N_FW), .TS_W(TS_W), .RD_W(RD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .attack_flag(attack_flag), .upd_done(upd_done),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .fw_block(fw_block), .serve_valid(serve_valid), .serve_id(serve_id)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd(input int addr, output int data);
        reg_addr = AW'(addr);
        #1;
        data = int'(reg_rdata);
    endtask

    task automatic w1c(input int addr, input int mask);
        reg_addr  = AW'(addr);
        reg_wdata = N_FW'(mask);
        reg_wr    = 1'b1;
        step();
        reg_wr    = 1'b0;
    endtask

    int stamp_exp [N_FW];

    initial begin
        int v, c, rem, low;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v);                chk("R1 summary", v, 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 block", int'(fw_block), 0);
        chk("R1 serve_valid", int'(serve_valid), 0);

        // R11 timestamp follows cycles
        rd(N_FW + 1, v);         chk("R11 ts", v, cyc & TSM);
        repeat (5) step();
        rd(N_FW + 1, v);         chk("R11 ts after 5", v, cyc & TSM);

        // R9 done while idle ignored
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R9 block", int'(fw_block), 0);
        chk("R9 serve_valid", int'(serve_valid), 0);

        // sweep over every non-empty flag pattern
        for (int pat = 1; pat < (1 << N_FW); pat++) begin
            c = cyc;
            attack_flag = N_FW'(pat);
            step();
            attack_flag = '0;
            rd(0, v);            chk("R2 summary", v, pat);
            chk("R4 irq set", int'(irq), 1);
            chk("R6 block", int'(fw_block), pat);
            for (int i = 0; i < N_FW; i++) begin
                if (pat[i]) begin
                    stamp_exp[i] = c & TSM;
                    rd(1 + i, v); chk("R3 stamp", v, stamp_exp[i]);
                end
            end
            rem = pat;
            for (int i = 0; i < N_FW; i++) begin
                if (pat[i]) begin
                    step();
                    chk("R7 serve_valid", int'(serve_valid), 1);
                    chk("R7 serve_id", int'(serve_id), i);
                    upd_done = 1'b1; step(); upd_done = 1'b0;
                    rem = rem & ~(1 << i);
                    chk("R8 block after release", int'(fw_block), rem);
                end
            end
            step();
            chk("R8 idle after queue", int'(serve_valid), 0);
            rd(0, v);            chk("R2 sticky", v, pat);
            low = pat & -pat;
            w1c(0, low);
            rd(0, v);            chk("R5 partial clear", v, pat & ~low);
            chk("R4 irq partial", int'(irq), ((pat & ~low) != 0) ? 1 : 0);
            w1c(0, (1 << N_FW) - 1);
            rd(0, v);            chk("R5 full clear", v, 0);
            chk("R4 irq clear", int'(irq), 0);
        end

        // R10 re-flag of blocked firewall
        attack_flag = 4'b0010; step();
        c = cyc;
        attack_flag = 4'b0010; step();
        attack_flag = '0;
        chk("R10 serve_id", int'(serve_id), 1);
        rd(2, v);                chk("R3 restamp", v, c & TSM);
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R10 released", int'(fw_block), 0);
        step(); step();
        chk("R10 no second serve", int'(serve_valid), 0);
        w1c(0, 4'b1111);

        // R5 flag wins over same-edge clear; other addresses ignore writes
        rd(3, c);
        attack_flag = 4'b0100;
        reg_addr = '0; reg_wdata = 4'b0100; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; attack_flag = '0;
        rd(0, v);                chk("R5 flag wins", v, 4);
        rd(3, c);
        w1c(3, 4'b1111);
        rd(0, v);                chk("R5 other addr ignored", v, 4);
        rd(3, v);                chk("R5 stamp unchanged", v, c);
        step();
        chk("R7 serve fw2", int'(serve_id), 2);
        upd_done = 1'b1; step(); upd_done = 1'b0;
        chk("R8 release fw2", int'(fw_block), 0);
        w1c(0, 4'b0100);
        chk("R4 irq low", int'(irq), 0);

        // R11 after wrap
        rd(N_FW + 1, v);         chk("R11 ts wrapped", v, cyc & TSM);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule